// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Store Access Controller

This block sits on a CPU's I/O register bus and gives software single-byte read and write access to a 4096-byte non-volatile data array. The array has its own address space. Four byte registers hold the state. Two of them together form a 12-bit byte address, one holds a data byte, and one is the command register. Software loads the address and data and then writes a strobe bit into the command register. A read strobe fetches the addressed byte into the data register. A write strobe starts a self-timed programming cycle.

Each accepted strobe raises a CPU hold request for a fixed number of cycles. A read holds the CPU longer than a write. Accesses to the address and data registers never hold it. Once the short write stall ends, the write continues in the background. A busy flag stays high until the byte has been committed, and software polls this flag. The design guards writes so that a stray access cannot start one. A separate arm bit must be set first, and the write strobe has to follow it within a short window. If the window lapses, the arm bit drops by itself.

Top module: `nvbyte_ctrl`

## Requirements
- R1: The register map uses four offsets on `bus_addr`. Offset 0 holds address bits 7:0 and offset 1 holds address bits 11:8 in its bits 3:0. Offset 2 is the data byte and offset 3 is the command register. A register read returns its value on `bus_rdata` one cycle after the read access.
- R2: Bits 7:4 of offset 1 always read as zero, and writes to them have no effect.
- R3: A read strobe (command bit 0) that is accepted loads the data register from the array at the current address. `cpu_hold` goes high the cycle after the strobe write and stays high for exactly 4 cycles.
- R4: An accepted write strobe (command bit 1) holds `cpu_hold` high for exactly 2 cycles. The busy flag (command bit 1 on readback) stays high for WR_CYCLES cycles after the strobe.
- R5: The address and data present when the write strobe is accepted are captured. That byte is committed to the array at that address when the busy period ends, and a later read of that address returns it.
- R6: A write strobe is accepted only if the arm bit (command bit 2) was already set by an earlier command write. The strobe must arrive within the 4 cycles that follow that write. A single command write that sets both the arm bit and the write strobe while the arm bit is clear starts nothing.
- R7: The arm bit clears itself 4 cycles after it was set if no write strobe is accepted in that time. It also clears when a write starts.
- R8: While busy, read and write strobes are ignored. No hold is raised, the data register keeps its value, and the array is left unchanged.
- R9: Writes to the address or data registers, register reads, and command writes that carry no accepted strobe never raise `cpu_hold`.
- R10: After reset all four registers read as zero and `cpu_hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_hold | output | 1 | CPU halt request |

## Verification
The bench measures the two stall lengths directly at `cpu_hold`. A design that swapped them, or stalled one cycle too long, shows up there at once. It probes the guard window on both sides of its last cycle and also sends the combined arm-and-strobe write. A guard that is off by one cycle, or that accepts the combined write, would start a write that should not happen. During a busy period it changes the address and data registers, then issues strobes that must be ignored. A design that commits the live registers instead of the captured ones, or that obeys strobes while busy, corrupts a neighbouring byte or the data register. A sweep across the address range with distinct data catches address bits that are dropped or aliased, including the high nibble that must read as zero.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_ALO = 2'd0,
    REG_AHI = 2'd1,
    REG_DAT = 2'd2,
    REG_CTL = 2'd3
  } nv_reg_e;

  localparam int CTL_RD  = 0;
  localparam int CTL_WR  = 1;
  localparam int CTL_ARM = 2;
  localparam int CTL_W   = 3;
endpackage

// File: rtl/nvbyte_array.sv
module nvbyte_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvbyte_regs.sv
module nvbyte_regs
  import nvbyte_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              arm,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              ctl_wr,
  output logic [CTL_W-1:0]  ctl_val
);
  localparam int HI_W = ADDR_W - BYTE_W;

  nv_reg_e            sel_reg;
  logic [BYTE_W-1:0]  hi_ext;
  logic [BYTE_W-1:0]  rd_mux;

  assign sel_reg = nv_reg_e'(bus_addr);
  assign ctl_wr  = bus_sel && bus_we && (sel_reg == REG_CTL);
  assign ctl_val = bus_wdata[CTL_W-1:0];

  // upper address nibble zero-extended; unused bits are constant zero
  generate
    if (HI_W < BYTE_W) begin : g_hi_pad
      assign hi_ext = {{(BYTE_W-HI_W){1'b0}}, addr_q[ADDR_W-1:BYTE_W]};
    end else begin : g_hi_full
      assign hi_ext = addr_q[ADDR_W-1:BYTE_W];
    end
  endgenerate

  always_comb begin
    unique case (sel_reg)
      REG_ALO: rd_mux = addr_q[BYTE_W-1:0];
      REG_AHI: rd_mux = hi_ext;
      REG_DAT: rd_mux = data_q;
      default: begin
        rd_mux = '0;
        rd_mux[CTL_WR]  = busy;
        rd_mux[CTL_ARM] = arm;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_sel && bus_we) begin
        case (sel_reg)
          REG_ALO: addr_q[BYTE_W-1:0]      <= bus_wdata;
          REG_AHI: addr_q[ADDR_W-1:BYTE_W] <= bus_wdata[HI_W-1:0];
          REG_DAT: data_q                  <= bus_wdata;
          default: ;
        endcase
      end
      if (load_en) data_q <= load_val;
      if (bus_sel && !bus_we) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
  import nvbyte_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ARM_WIN   = 4,
  parameter int RD_HOLD   = 4,
  parameter int WR_HOLD   = 2,
  parameter int WR_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_val,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [BYTE_W-1:0] data_q,
  output logic              cpu_hold,
  output logic              busy,
  output logic              arm,
  output logic              rd_acc,
  output logic              wr_acc,
  output logic              rd_load,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam int HOLD_MAX = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
  localparam int HCNT_W   = $clog2(HOLD_MAX + 1);
  localparam int BCNT_W   = $clog2(WR_CYCLES + 1);
  localparam int ACNT_W   = $clog2(ARM_WIN + 1);

  logic [HCNT_W-1:0] hcnt;
  logic [BCNT_W-1:0] bcnt;
  logic [ACNT_W-1:0] acnt;
  logic              rd_req, wr_req, arm_set;

  assign rd_req  = ctl_wr && ctl_val[CTL_RD];
  assign wr_req  = ctl_wr && ctl_val[CTL_WR];
  assign wr_acc  = wr_req && arm && !busy;
  assign rd_acc  = rd_req && !busy && !wr_acc;
  assign arm_set = ctl_wr && ctl_val[CTL_ARM] && !arm;
  assign mem_we  = busy && (bcnt == '0);

  // write guard: arm window
  always_ff @(posedge clk) begin
    if (rst) begin
      arm  <= 1'b0;
      acnt <= '0;
    end else if (wr_acc) begin
      arm <= 1'b0;
    end else if (arm_set) begin
      arm  <= 1'b1;
      acnt <= ACNT_W'(ARM_WIN - 1);
    end else if (arm) begin
      if (acnt == '0) arm <= 1'b0;
      else            acnt <= acnt - 1'b1;
    end
  end

  // self-timed background write
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bcnt      <= '0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else if (wr_acc) begin
      busy      <= 1'b1;
      bcnt      <= BCNT_W'(WR_CYCLES - 1);
      mem_waddr <= addr_q;
      mem_wdata <= data_q;
    end else if (busy) begin
      if (bcnt == '0) busy <= 1'b0;
      else            bcnt <= bcnt - 1'b1;
    end
  end

  // CPU stall sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_hold <= 1'b0;
      hcnt     <= '0;
      rd_load  <= 1'b0;
    end else begin
      rd_load <= rd_acc;
      if (rd_acc) begin
        cpu_hold <= 1'b1;
        hcnt     <= HCNT_W'(RD_HOLD - 1);
      end else if (wr_acc) begin
        cpu_hold <= 1'b1;
        hcnt     <= HCNT_W'(WR_HOLD - 1);
      end else if (cpu_hold) begin
        if (hcnt == '0) cpu_hold <= 1'b0;
        else            hcnt     <= hcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
  import nvbyte_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ARM_WIN   = 4,
  parameter int RD_HOLD   = 4,
  parameter int WR_HOLD   = 2,
  parameter int WR_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_hold
);
  logic [ADDR_W-1:0] addr_w, mem_waddr_w;
  logic [BYTE_W-1:0] data_w, mem_wdata_w, mem_rdata_w;
  logic [CTL_W-1:0]  ctl_val_w;
  logic              ctl_wr_w, busy_w, arm_w, rd_acc_w, wr_acc_w;
  logic              rd_load_w, mem_we_w;

  nvbyte_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .arm(arm_w),
    .load_en(rd_load_w), .load_val(mem_rdata_w),
    .addr_q(addr_w), .data_q(data_w),
    .ctl_wr(ctl_wr_w), .ctl_val(ctl_val_w)
  );

  nvbyte_seq #(
    .ADDR_W(ADDR_W), .ARM_WIN(ARM_WIN), .RD_HOLD(RD_HOLD),
    .WR_HOLD(WR_HOLD), .WR_CYCLES(WR_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr_w), .ctl_val(ctl_val_w),
    .addr_q(addr_w), .data_q(data_w),
    .cpu_hold(cpu_hold), .busy(busy_w), .arm(arm_w),
    .rd_acc(rd_acc_w), .wr_acc(wr_acc_w), .rd_load(rd_load_w),
    .mem_we(mem_we_w), .mem_waddr(mem_waddr_w), .mem_wdata(mem_wdata_w)
  );

  nvbyte_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk(clk), .we(mem_we_w),
    .waddr(mem_waddr_w), .wdata(mem_wdata_w),
    .raddr(addr_w), .rdata(mem_rdata_w)
  );
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(
  parameter int ADDR_W  = 12,
  parameter int ARM_WIN = 4,
  parameter int RD_HOLD = 4,
  parameter int WR_HOLD = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       cpu_hold,
  input logic       busy,
  input logic       arm,
  input logic       wr_acc,
  input logic       mem_we
);
  logic [15:0] hold_run;
  logic [15:0] arm_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_run <= '0;
      arm_run  <= '0;
    end else begin
      hold_run <= cpu_hold ? hold_run + 1'b1 : '0;
      arm_run  <= arm ? arm_run + 1'b1 : '0;
    end
  end

  // R3 / R4: every completed stall has one of the two fixed lengths
  a_r3_stall_length: assert property (@(posedge clk) disable iff (rst)
    (!cpu_hold && hold_run != 0) |-> (hold_run == RD_HOLD || hold_run == WR_HOLD));

  a_r4_write_starts_busy: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> (busy && cpu_hold));

  a_r5_commit_at_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_we));

  a_r6_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(arm));

  a_r7_arm_window: assert property (@(posedge clk) disable iff (rst)
    arm |-> (arm_run < ARM_WIN));

  a_r8_no_stall_when_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> !$past(busy));

  a_r9_stall_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> $past(bus_sel && bus_we && bus_addr == 2'd3));

  a_r2_high_nibble_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_we && bus_addr == 2'd1) |-> ((bus_rdata >> (ADDR_W - 8)) == 8'd0));
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(
  .ADDR_W(ADDR_W), .ARM_WIN(ARM_WIN), .RD_HOLD(RD_HOLD), .WR_HOLD(WR_HOLD)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cpu_hold(cpu_hold),
  .busy(busy_w), .arm(arm_w), .wr_acc(wr_acc_w), .mem_we(mem_we_w)
);

// File: tb/nvbyte_ctrl_test.sv
module nvbyte_ctrl_test;
  localparam int WRC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cpu_hold;

  int checks = 0;
  int fails  = 0;

  nvbyte_ctrl #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_hold(cpu_hold)
  );

  always #2.5 clk = ~clk;

  // {address[11:0], data[7:0]}
  localparam logic [19:0] VEC [12] = '{
    20'h000_A5, 20'hFFF_3C, 20'h800_81, 20'h7FF_7E,
    20'h123_00, 20'hABC_FF, 20'h555_55, 20'hAAA_AA,
    20'h0FE_12, 20'hF01_E1, 20'h001_69, 20'hFFE_96
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks are entered and left on a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_addr(input logic [11:0] a);
    bus_write(2'd0, a[7:0]);
    bus_write(2'd1, {4'h0, a[11:8]});
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 4 * WRC; i++) begin
      bus_read(2'd3, v);
      if (!v[1]) break;
    end
  endtask

  task automatic measure_hold(output int n);
    n = 0;
    while (cpu_hold && n < 64) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    set_addr(a);
    bus_write(2'd2, d);
    bus_write(2'd3, 8'h04);
    bus_write(2'd3, 8'h02);
    wait_idle();
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] d);
    set_addr(a);
    bus_write(2'd3, 8'h01);
    repeat (5) @(negedge clk);
    bus_read(2'd2, d);
  endtask

  function automatic logic [7:0] sweep_val(input int a);
    return 8'(a ^ (a >> 4) ^ 8'h5A);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk("R10 hold after reset", cpu_hold, 0);
    for (int r = 0; r < 4; r++) begin
      bus_read(2'(r), v);
      chk("R10 register reset value", v, 0);
    end

    // R1 / R2 / R9: register access, no stall
    bus_write(2'd0, 8'hC7);
    chk("R9 no hold on address write", cpu_hold, 0);
    bus_read(2'd0, v);
    chk("R1 low address readback", v, 8'hC7);
    bus_write(2'd1, 8'hF3);
    bus_read(2'd1, v);
    chk("R2 high nibble reads zero", v, 8'h03);
    bus_write(2'd2, 8'h9D);
    chk("R9 no hold on data write", cpu_hold, 0);
    bus_read(2'd2, v);
    chk("R1 data readback", v, 8'h9D);
    bus_write(2'd3, 8'h04);
    chk("R9 no hold on arm-only write", cpu_hold, 0);
    repeat (6) @(negedge clk);

    // R5: sweep across the address range
    for (int a = 0; a < 4096; a += 17) do_write(12'(a), sweep_val(a));
    for (int a = 0; a < 4096; a += 17) begin
      do_read(12'(a), v);
      chk("R5 sweep readback", v, sweep_val(a));
    end

    // R1 / R5: vector table, write all then read all
    foreach (VEC[i]) do_write(VEC[i][19:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      do_read(VEC[i][19:8], v);
      chk("R5 table readback", v, VEC[i][7:0]);
    end

    // R3: read stall length and data
    set_addr(VEC[5][19:8]);
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h01);
    measure_hold(n);
    chk("R3 read hold cycles", n, 4);
    bus_read(2'd2, v);
    chk("R3 read loads data", v, VEC[5][7:0]);

    // R4: write stall length
    set_addr(12'h321);
    bus_write(2'd2, 8'h4B);
    bus_write(2'd3, 8'h04);
    bus_write(2'd3, 8'h02);
    measure_hold(n);
    chk("R4 write hold cycles", n, 2);
    wait_idle();

    // R4: busy length, R7: arm cleared by write start
    bus_write(2'd3, 8'h04);
    bus_write(2'd3, 8'h02);
    repeat (WRC - 1) @(negedge clk);
    bus_read(2'd3, v);
    chk("R4 busy on last cycle", v[1], 1);
    chk("R7 arm cleared by write start", v[2], 0);
    bus_read(2'd3, v);
    chk("R4 busy cleared after WR_CYCLES", v[1], 0);

    // R7: arm expiry
    bus_write(2'd3, 8'h04);
    bus_read(2'd3, v);
    chk("R7 arm set", v[2], 1);
    repeat (3) @(negedge clk);
    bus_read(2'd3, v);
    chk("R7 arm expired", v[2], 0);

    // R6: strobe one cycle after window is rejected
    set_addr(VEC[6][19:8]);
    bus_write(2'd2, 8'h11);
    bus_write(2'd3, 8'h04);
    repeat (4) @(negedge clk);
    bus_write(2'd3, 8'h02);
    chk("R6 late strobe no hold", cpu_hold, 0);
    bus_read(2'd3, v);
    chk("R6 late strobe not busy", v[1], 0);
    // R6: combined arm + strobe from clear arm starts nothing
    bus_write(2'd3, 8'h06);
    chk("R6 combined write no hold", cpu_hold, 0);
    bus_read(2'd3, v);
    chk("R6 combined write not busy", v[1], 0);
    repeat (6) @(negedge clk);
    do_read(VEC[6][19:8], v);
    chk("R6 array untouched by rejected strobes", v, VEC[6][7:0]);

    // R6: strobe on last window cycle is accepted
    set_addr(VEC[6][19:8]);
    bus_write(2'd2, 8'h22);
    bus_write(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    bus_write(2'd3, 8'h02);
    chk("R6 last-cycle strobe accepted", cpu_hold, 1);
    wait_idle();
    do_read(VEC[6][19:8], v);
    chk("R6 accepted write data", v, 8'h22);

    // R8 / R5: strobes ignored while busy, captured values committed
    set_addr(VEC[2][19:8]);
    bus_write(2'd2, 8'hD1);
    bus_write(2'd3, 8'h04);
    bus_write(2'd3, 8'h02);
    bus_write(2'd2, 8'hD2);
    set_addr(VEC[3][19:8]);
    bus_write(2'd3, 8'h01);
    chk("R8 read strobe while busy no hold", cpu_hold, 0);
    repeat (5) @(negedge clk);
    bus_read(2'd2, v);
    chk("R8 data register unchanged", v, 8'hD2);
    bus_write(2'd3, 8'h04);
    bus_write(2'd3, 8'h02);
    chk("R8 write strobe while busy no hold", cpu_hold, 0);
    wait_idle();
    repeat (6) @(negedge clk);
    do_read(VEC[3][19:8], v);
    chk("R8 neighbour byte unchanged", v, VEC[3][7:0]);
    do_read(VEC[2][19:8], v);
    chk("R5 captured byte committed", v, 8'hD1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule